// File: doc/BRIEF.md
# Paged Data-RAM Access Controller

This block connects the external-data move path of a small microcontroller core to a 1 KB on-chip data RAM. A move request names its address in one of two ways. In pointer mode the request carries a full 16-bit address. In indexed mode the request carries only an 8-bit low byte, and a page register that software can write supplies the high byte. A read or write whose 16-bit address lands in the RAM window at the top of the 64 KB data space (FC00h up to FFFFh) is served from the RAM. Any other access is reported as external and leaves the RAM untouched.

The page register does for the on-chip RAM what the upper port byte does for off-chip data memory. Software reaches it on the special-function-register (SFR) bus at address 91h, where all eight bits can be read and written. A read returns its data on a registered strobe one clock after the request. A write takes effect on the clock edge that accepts it.

Top module: `xram_pager`

## Requirements
- R1: After reset the page register holds 00h. Reading SFR address 91h returns 00h, and `rd_valid`, `ext_flag` and `sfr_rd_en` are all low.
- R2: An SFR write to 91h loads all eight bits of the page register. An SFR read of 91h returns the current page value on `sfr_rdata`, with `sfr_rd_en` high, in the cycle after the read request.
- R3: An SFR read at any address other than 91h leaves `sfr_rd_en` low and `sfr_rdata` at 00h. An SFR write at any other address leaves the page register unchanged.
- R4: A pointer-mode access (`req_mode`=0) whose address lies in FC00h..FFFFh is served internally. For a read, `rd_valid` goes high and `rd_data` holds the stored byte in the cycle after the request, and `ext_flag` stays low.
- R5: A pointer-mode access below FC00h raises `ext_flag` for one cycle, in the cycle after the request. `rd_valid` stays low and the RAM is not written.
- R6: An indexed-mode access (`req_mode`=1) forms its address as {page, `req_idx`}, with the page as bits 15..8 and the index as bits 7..0. It is served internally when that address lies in FC00h..FFFFh.
- R7: An indexed-mode access whose formed address falls below FC00h raises `ext_flag`, does not raise `rd_valid`, and leaves the RAM unchanged.
- R8: A write commits on the clock edge that accepts the request, so a read of the same address in the next cycle returns the new byte.
- R9: When an SFR write to the page register and an indexed move occur in the same cycle, the move uses the old page value. The new page applies from the next cycle on.
- R10: The RAM cell is chosen by address bits 9..0. A pointer address and an indexed address that form the same 16-bit value reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Move request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 1 | 0 = pointer (16-bit address), 1 = indexed (page + byte) |
| req_ptr | input | 16 | Full address for pointer mode |
| req_idx | input | 8 | Low address byte for indexed mode |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data from the RAM is valid |
| rd_data | output | 8 | Read data |
| ext_flag | output | 1 | Previous request missed the RAM window |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | SFR read data (00h when not selected) |
| sfr_rd_en | output | 1 | This block drives SFR read data |

## Verification
Two functions can fall in the same cycle: a page-register write on the SFR bus and an indexed move that depends on that register. The bench issues both in one cycle, some cases directed and many random, with page values on both sides of the window edge. It then judges the move's routing and the RAM contents against a model that applies the old page to the move and the new page only from the next cycle on. The same cycles can also carry an SFR read of 91h, and that read must return the value from before the write.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
  typedef enum logic {
    MODE_PTR = 1'b0,
    MODE_IDX = 1'b1
  } xpg_mode_e;
endpackage

// File: rtl/xpg_page_reg.sv
module xpg_page_reg #(
  parameter int          SFR_AW    = 8,
  parameter int          PAGE_W    = 8,
  parameter logic [7:0]  PAGE_ADDR = 8'h91
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [PAGE_W-1:0] sfr_wdata,
  input  logic              sfr_rd,
  output logic [PAGE_W-1:0] page,
  output logic [PAGE_W-1:0] sfr_rdata,
  output logic              sfr_rd_en
);
  logic              sel;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] rdata_q;
  logic              rd_en_q;

  assign sel = (sfr_addr == SFR_AW'(PAGE_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      rdata_q <= '0;
      rd_en_q <= 1'b0;
    end else begin
      if (sfr_wr && sel) page_q <= sfr_wdata;
      rd_en_q <= sfr_rd && sel;
      rdata_q <= (sfr_rd && sel) ? page_q : '0;
    end
  end

  assign page      = page_q;
  assign sfr_rdata = rdata_q;
  assign sfr_rd_en = rd_en_q;

  // R2: page changes only after a selected write
  a_r2_page_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(sfr_wr && sel) |-> $stable(page_q));
  // R3: read enable only follows a selected read
  a_r3_rden_select: assert property (@(posedge clk) disable iff (rst)
    sfr_rd_en |-> $past(sfr_rd && sel));
endmodule

// File: rtl/xpg_addr_decode.sv
module xpg_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int RAM_AW = 10,
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              mode,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              hit,
  output logic [RAM_AW-1:0] ram_addr
);
  import xpg_pkg::*;

  always_comb begin
    if (xpg_mode_e'(mode) == MODE_IDX) eff_addr = {page, idx};
    else                               eff_addr = ptr;
  end

  assign hit      = &eff_addr[ADDR_W-1:RAM_AW];
  assign ram_addr = eff_addr[RAM_AW-1:0];
endmodule

// File: rtl/xpg_ram.sv
module xpg_ram #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xram_pager.sv
module xram_pager #(
  parameter int         ADDR_W    = 16,
  parameter int         DATA_W    = 8,
  parameter int         IDX_W     = 8,
  parameter int         RAM_AW    = 10,
  parameter int         SFR_AW    = 8,
  parameter logic [7:0] PAGE_ADDR = 8'h91,
  localparam int        PAGE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ext_flag,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [PAGE_W-1:0] sfr_wdata,
  input  logic              sfr_rd,
  output logic [PAGE_W-1:0] sfr_rdata,
  output logic              sfr_rd_en
);
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] eff_addr;
  logic              hit;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we, ram_re;
  logic              rd_valid_q, ext_q;

  xpg_page_reg #(.SFR_AW(SFR_AW), .PAGE_W(PAGE_W), .PAGE_ADDR(PAGE_ADDR)) u_page (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .page(page),
    .sfr_rdata(sfr_rdata), .sfr_rd_en(sfr_rd_en)
  );

  xpg_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_AW(RAM_AW)) u_dec (
    .mode(req_mode), .ptr(req_ptr), .idx(req_idx), .page(page),
    .eff_addr(eff_addr), .hit(hit), .ram_addr(ram_addr)
  );

  assign ram_we = req_valid &&  req_write && hit;
  assign ram_re = req_valid && !req_write && hit;

  xpg_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(req_wdata), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      ext_q      <= 1'b0;
    end else begin
      rd_valid_q <= ram_re;
      ext_q      <= req_valid && !hit;
    end
  end

  assign rd_valid = rd_valid_q;
  assign ext_flag = ext_q;

  // R4: read strobe only one cycle after a read request
  a_r4_rdvalid_timing: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write));
  // R5: external flag only after a request
  a_r5_ext_after_req: assert property (@(posedge clk) disable iff (rst)
    ext_flag |-> $past(req_valid));
  // R7: an access is never both served and external
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && ext_flag));
endmodule

// File: tb/xram_pager_test.sv
`timescale 1ns/1ps
module xram_pager_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_mode;
  logic [15:0] req_ptr;
  logic [7:0]  req_idx, req_wdata;
  logic        rd_valid, ext_flag;
  logic [7:0]  rd_data;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_wr, sfr_rd, sfr_rd_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] shadow [1024];
  logic [7:0] page_m;

  always #2.5 clk = ~clk;

  xram_pager uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_ptr(req_ptr), .req_idx(req_idx),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ext_flag(ext_flag), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .sfr_rd_en(sfr_rd_en)
  );

  function automatic bit in_win(input logic [15:0] a);
    return a[15:10] == 6'h3F;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_mode = 0; req_ptr = 0; req_idx = 0;
    req_wdata = 0; sfr_addr = 0; sfr_wr = 0; sfr_wdata = 0; sfr_rd = 0;
  endtask

  // one cycle: drive at negedge, check at next negedge against the model
  task automatic step(input bit mv, input bit wr, input bit md,
                      input logic [15:0] ptr, input logic [7:0] idx,
                      input logic [7:0] wd, input bit sw, input bit sr,
                      input logic [7:0] sa, input logic [7:0] swd,
                      input string note);
    logic [15:0] eff;
    bit hit, exp_rdv, exp_ext, exp_sren;
    logic [7:0] exp_rd, exp_srd;
    string t;
    req_valid = mv; req_write = wr; req_mode = md; req_ptr = ptr;
    req_idx = idx; req_wdata = wd; sfr_wr = sw; sfr_rd = sr;
    sfr_addr = sa; sfr_wdata = swd;
    eff = md ? {page_m, idx} : ptr;   // old page (R9)
    hit = in_win(eff);
    exp_rdv = mv && !wr && hit;
    exp_ext = mv && !hit;
    exp_rd  = shadow[eff[9:0]];
    exp_sren = sr && (sa == 8'h91);
    exp_srd  = exp_sren ? page_m : 8'h00;
    if (mv && wr && hit) shadow[eff[9:0]] = wd;
    if (sw && sa == 8'h91) page_m = swd;
    @(negedge clk);
    idle();
    t = md ? (hit ? "R6" : "R7") : (hit ? "R4" : "R5");
    if (note != "") t = {note, "/", t};
    if (mv) begin
      chk(rd_valid == exp_rdv, {t, " rd_valid"}, rd_valid, exp_rdv);
      chk(ext_flag == exp_ext, {t, " ext_flag"}, ext_flag, exp_ext);
      if (exp_rdv) chk(rd_data == exp_rd, {t, " rd_data"}, rd_data, exp_rd);
    end
    if (sr) begin
      chk(sfr_rd_en == exp_sren, {(exp_sren ? "R2" : "R3"), " sfr_rd_en"}, sfr_rd_en, exp_sren);
      chk(sfr_rdata == exp_srd, {(exp_sren ? "R2" : "R3"), " sfr_rdata"}, sfr_rdata, exp_srd);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    step(0, 0, 0, 0, 0, 0, 1, 0, a, d, "");
  endtask
  task automatic sfr_read(input logic [7:0] a, input string n);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, 0, n);
  endtask
  task automatic ptr_rd(input logic [15:0] a, input string n);
    step(1, 0, 0, a, 0, 0, 0, 0, 0, 0, n);
  endtask
  task automatic ptr_wr(input logic [15:0] a, input logic [7:0] d, input string n);
    step(1, 1, 0, a, 0, d, 0, 0, 0, 0, n);
  endtask
  task automatic idx_mv(input bit wr, input logic [7:0] i, input logic [7:0] d, input string n);
    step(1, wr, 1, 0, i, d, 0, 0, 0, 0, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pages [6];
    void'($urandom(32'h5EED_1234));
    pages = '{8'hFC, 8'hFD, 8'hFE, 8'hFF, 8'hFB, 8'h00};
    idle();
    page_m = 8'h00;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(ext_flag == 0, "R1 ext_flag", ext_flag, 0);
    chk(sfr_rd_en == 0, "R1 sfr_rd_en", sfr_rd_en, 0);
    sfr_read(8'h91, "R1");
    // prefill whole RAM through pointer mode (R8 write path)
    for (int i = 0; i < 1024; i++) ptr_wr(16'hFC00 + 16'(i), 8'(i * 7 + 3), "R8");
    // R2: page write/readback
    sfr_write(8'h91, 8'hA5); sfr_read(8'h91, "R2");
    sfr_write(8'h91, 8'h5A); sfr_read(8'h91, "R2");
    // R3: other addresses
    sfr_read(8'h90, "R3");
    sfr_write(8'h92, 8'hFF); sfr_read(8'h91, "R3");
    // R4/R5: window edges
    ptr_rd(16'hFC00, "R4"); ptr_rd(16'hFFFF, "R4");
    ptr_rd(16'hFBFF, "R5");
    ptr_wr(16'h0000, 8'hEE, "R5"); ptr_rd(16'hFC00, "R5");
    ptr_wr(16'hFBFF, 8'hEE, "R5"); ptr_rd(16'hFFFF, "R5");
    // R8: write then immediate read
    ptr_wr(16'hFE77, 8'h91, "R8"); ptr_rd(16'hFE77, "R8");
    // R10: aliasing of indexed and pointer
    sfr_write(8'h91, 8'hFD);
    idx_mv(1, 8'h23, 8'h3C, "R10"); ptr_rd(16'hFD23, "R10");
    ptr_wr(16'hFD40, 8'hC3, "R10"); idx_mv(0, 8'h40, 0, "R10");
    // R7: indexed miss leaves RAM unchanged
    sfr_write(8'h91, 8'h00);
    idx_mv(1, 8'h23, 8'h11, "R7"); ptr_rd(16'hFC23, "R7"); ptr_rd(16'hFD23, "R7");
    sfr_write(8'h91, 8'hFB); idx_mv(0, 8'hFF, 0, "R7");
    // R9: same-cycle page write and indexed move
    sfr_write(8'h91, 8'hFD);
    step(1, 1, 1, 0, 8'h10, 8'h77, 1, 1, 8'h91, 8'hFE, "R9");
    ptr_rd(16'hFD10, "R9"); ptr_rd(16'hFE10, "R9");
    step(1, 1, 1, 0, 8'h11, 8'h66, 1, 0, 8'h91, 8'h00, "R9");
    idx_mv(1, 8'h11, 8'h55, "R9");
    ptr_rd(16'hFE11, "R9"); ptr_rd(16'hFC11, "R9");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit mv, wr, md, sw, sr;
      logic [15:0] p;
      logic [7:0] sa;
      mv = ($urandom % 4) != 0;
      wr = $urandom % 2;
      md = $urandom % 2;
      p  = ($urandom % 4 == 0) ? 16'($urandom) : {6'h3E + 6'($urandom % 2), 10'($urandom)};
      sw = ($urandom % 5) == 0;
      sr = ($urandom % 3) == 0;
      sa = ($urandom % 4 == 0) ? 8'($urandom) : 8'h91;
      step(mv, wr, md, p, 8'($urandom), 8'($urandom), sw, sr, sa,
           pages[$urandom % 6], "");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule